// File: doc/BRIEF.md
# Serial Host Register and Data-Group CRC Port

This block is the host-facing serial port of a broadcast data receiver. A host drives three lines (serial clock, enable, data in) and observes one open-drain data-out line. Every transaction opens with an address byte shifted in while enable is low. The byte is decoded when enable rises and selects one of three data phases:
- a write into a small control register file (allowed error count, block sync protection count, frame sync protection count, two control bytes);
- a streaming readback of the status byte followed by the block number byte;
- a byte stream fed to a data-group CRC checker. Its pass flag drives a dedicated output pin and status bit 1.

The serial lines are asynchronous to the system clock. They pass through two-flop synchronisers, and all shifting happens on the detected rising edge of the serial clock. The serial link has no back-pressure. The host paces the bits, and every serial level must stay stable for at least three system clock cycles. The block accepts each bit when it sees the edge and never stalls the host.

Register writes are refused for a hold-off time after reset is released. The CRC stream may be cut into any number of transactions. It restarts only when the feed address arrives after a reset or after an explicit restart request.

Top module: `sreg_crc_port`

## Requirements
- R1: The address byte is taken from the last eight data-in bits captured on serial clock rises while enable is low, first bit as bit 0 (low nibble first, then high nibble), and is decoded when enable rises; 8'hA1 selects register write, 8'hA2 readback, 8'hA3 CRC feed, any other value a data phase that is ignored.
- R2: In a register write the data phase carries a 4-bit index (bit 0 first) then an 8-bit value (bit 0 first); on the twelfth bit the value lands in the register of that index: 1 allowed errors, 2 block sync protection, 3 frame sync protection, 4 control A, 5 control B; bits after the twelfth are ignored.
- R3: Index 0 and indices 7 to 15 change no register; index 6 changes no register and only arms a CRC restart.
- R4: Writes are ignored until HOLDOFF_NS (rounded up to whole clock cycles) has passed since reset release.
- R5: In a readback, status is captured when enable rises, with bit 1 replaced by the CRC pass flag; the line shows status bit 0 at once and moves one bit on every serial clock rise, status bits 0..7 then block number bits 0..7.
- R6: sdo_pull_low (1 = line pulled low) is high only while a readback is active and the current bit is 0; the line is released while enable is low, in other data phases and after the sixteenth readback bit.
- R7: In a CRC feed, every eight data bits form a byte (first bit = bit 0), processed MSB first into an 8-bit CRC with polynomial CRC_POLY (default 8'h07); crc_ok is high when the residue is zero; an incomplete byte left when enable falls is dropped.
- R8: The residue carries over between CRC feed transactions; it is cleared only when the feed address is decoded while a restart is armed, and a restart is armed by reset and by a write to index 6.
- R9: After reset all registers are 0, crc_ok is 1 and the data-out line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_en | input | 1 | Serial enable: low = address phase, high = data phase |
| ser_din | input | 1 | Serial data in |
| stat_in | input | 8 | Status byte from the receiver (bit 1 replaced by the CRC flag) |
| blkno_in | input | 8 | Block number from the receiver |
| sdo_pull_low | output | 1 | Open-drain drive: 1 pulls data-out low, 0 releases it |
| crc_ok | output | 1 | Data-group CRC pass flag |
| err_allow | output | 8 | Allowed error count register |
| blk_prot | output | 8 | Block sync protection count register |
| frm_prot | output | 8 | Frame sync protection count register |
| ctl_a | output | 8 | Control register A |
| ctl_b | output | 8 | Control register B |

## Verification
Writes to every valid index use distinct values, so a wrong index decode or bit order shows up as a swapped or mirrored register. Reserved indices, an unknown address and early writes inside the hold-off window must all leave the registers untouched. The CRC path gets one standard nine-byte check string, cut across three transactions, plus its appended check byte. The residue reaches zero only if the state carried over and byte assembly was aligned. A dangling partial byte followed by a zero byte separates proper bit-count reset from leakage. Readbacks with the CRC flag in both states, and with patterns that differ between status and block number, confirm field order and bit 1 substitution.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [2:0] {
    PH_ADDR  = 3'd0,
    PH_WRITE = 3'd1,
    PH_READ  = 3'd2,
    PH_CRC   = 3'd3,
    PH_SKIP  = 3'd4
  } phase_t;

  typedef struct packed {
    logic [7:0] err_allow;
    logic [7:0] blk_prot;
    logic [7:0] frm_prot;
    logic [7:0] ctl_a;
    logic [7:0] ctl_b;
  } regs_t;

  // One byte into the CRC, most significant bit first.
  function automatic logic [7:0] crc8_step(input logic [7:0] c,
                                           input logic [7:0] d,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_async[g];
        s2 <= s1;
      end
    end
    assign d_sync[g] = s2;
  end
endmodule

// File: rtl/sreg_frontend.sv
module sreg_frontend
  import sreg_pkg::*;
#(
  parameter logic [7:0] ADDR_WR  = 8'hA1,
  parameter logic [7:0] ADDR_RD  = 8'hA2,
  parameter logic [7:0] ADDR_CRC = 8'hA3,
  parameter int         IDX_W    = 4,
  parameter int         DAT_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_s,
  input  logic                 en_s,
  input  logic                 din_s,
  input  logic [2*DAT_W-1:0]   rd_word,
  output logic                 wr_vld,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [DAT_W-1:0]     wr_val,
  output logic                 crc_start,
  output logic                 byte_vld,
  output logic [DAT_W-1:0]     byte_val,
  output logic                 sdo_pull_low
);
  localparam int WR_BITS = IDX_W + DAT_W;
  localparam int RD_BITS = 2 * DAT_W;
  localparam int SR_W    = WR_BITS;
  localparam int CNT_W   = $clog2(RD_BITS + 1) + 1;
  localparam int BYTE_CW = $clog2(DAT_W);

  phase_t             phase;
  logic               sclk_d, en_d;
  logic [7:0]         addr_sr;
  logic [SR_W-1:0]    data_sr;
  logic [SR_W-1:0]    shift_nxt;
  logic [CNT_W-1:0]   cnt;
  logic [RD_BITS-1:0] rd_sr;
  logic [CNT_W-1:0]   rd_left;
  logic               sclk_rise, en_rise, en_fall;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign en_rise   = en_s & ~en_d;
  assign en_fall   = ~en_s & en_d;
  assign shift_nxt = {din_s, data_sr[SR_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_ADDR;
      sclk_d    <= 1'b0;
      en_d      <= 1'b0;
      addr_sr   <= '0;
      data_sr   <= '0;
      cnt       <= '0;
      rd_sr     <= '0;
      rd_left   <= '0;
      wr_vld    <= 1'b0;
      wr_idx    <= '0;
      wr_val    <= '0;
      crc_start <= 1'b0;
      byte_vld  <= 1'b0;
      byte_val  <= '0;
    end else begin
      sclk_d    <= sclk_s;
      en_d      <= en_s;
      wr_vld    <= 1'b0;
      crc_start <= 1'b0;
      byte_vld  <= 1'b0;
      if (en_fall) begin
        phase   <= PH_ADDR;
        rd_left <= '0;
      end else if (en_rise) begin
        cnt <= '0;
        if (addr_sr == ADDR_WR) begin
          phase <= PH_WRITE;
        end else if (addr_sr == ADDR_RD) begin
          phase   <= PH_READ;
          rd_sr   <= rd_word;
          rd_left <= CNT_W'(RD_BITS);
        end else if (addr_sr == ADDR_CRC) begin
          phase     <= PH_CRC;
          crc_start <= 1'b1;
        end else begin
          phase <= PH_SKIP;
        end
      end else if (sclk_rise) begin
        if (!en_s) begin
          addr_sr <= {din_s, addr_sr[7:1]};
        end else begin
          case (phase)
            PH_WRITE: begin
              if (cnt < CNT_W'(WR_BITS)) begin
                cnt     <= cnt + 1'b1;
                data_sr <= shift_nxt;
                if (cnt == CNT_W'(WR_BITS - 1)) begin
                  wr_vld <= 1'b1;
                  wr_idx <= shift_nxt[IDX_W-1:0];
                  wr_val <= shift_nxt[SR_W-1:IDX_W];
                end
              end
            end
            PH_CRC: begin
              cnt     <= cnt + 1'b1;
              data_sr <= shift_nxt;
              if (cnt[BYTE_CW-1:0] == BYTE_CW'(DAT_W - 1)) begin
                byte_vld <= 1'b1;
                byte_val <= shift_nxt[SR_W-1:SR_W-DAT_W];
              end
            end
            PH_READ: begin
              if (rd_left != '0) begin
                rd_sr   <= rd_sr >> 1;
                rd_left <= rd_left - 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sdo_pull_low = (phase == PH_READ) && (rd_left != '0) && !rd_sr[0];

  AST_SDO_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && !en_d) |-> !sdo_pull_low); // R6

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> !wr_vld); // R2

  AST_NO_WR_OUTSIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_WRITE) |=> !wr_vld); // R1

  AST_READ_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_left <= CNT_W'(RD_BITS)); // R5

endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile
  import sreg_pkg::*;
#(
  parameter int CLK_NS     = 8,
  parameter int HOLDOFF_NS = 300,
  parameter int IDX_W      = 4,
  parameter int DAT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DAT_W-1:0] wr_val,
  output regs_t            regs,
  output logic             crc_arm
);
  localparam int READY_CYC = (HOLDOFF_NS + CLK_NS - 1) / CLK_NS;
  localparam int RC_W      = $clog2(READY_CYC + 1) + 1;

  logic [RC_W-1:0] wait_cnt;
  logic            ready;
  regs_t           regs_q;

  assign ready = (wait_cnt == RC_W'(READY_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (!ready) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q  <= '0;
      crc_arm <= 1'b0;
    end else begin
      crc_arm <= 1'b0;
      if (wr_vld && ready) begin
        case (wr_idx)
          IDX_W'(1): regs_q.err_allow <= wr_val;
          IDX_W'(2): regs_q.blk_prot  <= wr_val;
          IDX_W'(3): regs_q.frm_prot  <= wr_val;
          IDX_W'(4): regs_q.ctl_a     <= wr_val;
          IDX_W'(5): regs_q.ctl_b     <= wr_val;
          IDX_W'(6): crc_arm          <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign regs = regs_q;

  AST_HOLDOFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(regs_q)); // R4

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && (wr_idx == '0 || wr_idx >= IDX_W'(6))) |=> $stable(regs_q)); // R3

endmodule

// File: rtl/sreg_crc.sv
module sreg_crc
  import sreg_pkg::*;
#(
  parameter logic [7:0] CRC_POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crc_arm,
  input  logic       crc_start,
  input  logic       byte_vld,
  input  logic [7:0] byte_val,
  output logic       crc_ok
);
  logic [7:0] crc_q;
  logic       fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      fresh <= 1'b1;
    end else begin
      if (crc_arm) begin
        fresh <= 1'b1;
      end else if (crc_start && fresh) begin
        fresh <= 1'b0;
        crc_q <= '0;
      end else if (byte_vld) begin
        crc_q <= crc8_step(crc_q, byte_val, CRC_POLY);
      end
    end
  end

  assign crc_ok = (crc_q == 8'h00);

  AST_CRC_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_start && fresh && !crc_arm) |=> (crc_ok && !fresh)); // R8

  AST_CRC_HOLDS_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !crc_start) |=> $stable(crc_q)); // R7

endmodule

// File: rtl/sreg_crc_port.sv
module sreg_crc_port
  import sreg_pkg::*;
#(
  parameter int         CLK_NS     = 8,
  parameter int         HOLDOFF_NS = 300,
  parameter logic [7:0] ADDR_WR    = 8'hA1,
  parameter logic [7:0] ADDR_RD    = 8'hA2,
  parameter logic [7:0] ADDR_CRC   = 8'hA3,
  parameter logic [7:0] CRC_POLY   = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_en,
  input  logic       ser_din,
  input  logic [7:0] stat_in,
  input  logic [7:0] blkno_in,
  output logic       sdo_pull_low,
  output logic       crc_ok,
  output logic [7:0] err_allow,
  output logic [7:0] blk_prot,
  output logic [7:0] frm_prot,
  output logic [7:0] ctl_a,
  output logic [7:0] ctl_b
);
  localparam int IDX_W = 4;
  localparam int DAT_W = 8;

  logic [2:0]       sync_q;
  logic             wr_vld, crc_start, byte_vld, crc_arm;
  logic [IDX_W-1:0] wr_idx;
  logic [DAT_W-1:0] wr_val, byte_val;
  logic [15:0]      rd_word;
  regs_t            regs;

  sreg_sync #(.W(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({ser_din, ser_en, ser_clk}),
    .d_sync  (sync_q)
  );

  assign rd_word = {blkno_in, stat_in[7:2], crc_ok, stat_in[0]};

  sreg_frontend #(
    .ADDR_WR (ADDR_WR), .ADDR_RD (ADDR_RD), .ADDR_CRC(ADDR_CRC),
    .IDX_W   (IDX_W),   .DAT_W   (DAT_W)
  ) u_front (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_s       (sync_q[0]),
    .en_s         (sync_q[1]),
    .din_s        (sync_q[2]),
    .rd_word      (rd_word),
    .wr_vld       (wr_vld),
    .wr_idx       (wr_idx),
    .wr_val       (wr_val),
    .crc_start    (crc_start),
    .byte_vld     (byte_vld),
    .byte_val     (byte_val),
    .sdo_pull_low (sdo_pull_low)
  );

  sreg_regfile #(
    .CLK_NS(CLK_NS), .HOLDOFF_NS(HOLDOFF_NS), .IDX_W(IDX_W), .DAT_W(DAT_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_vld  (wr_vld),
    .wr_idx  (wr_idx),
    .wr_val  (wr_val),
    .regs    (regs),
    .crc_arm (crc_arm)
  );

  sreg_crc #(.CRC_POLY(CRC_POLY)) u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_arm   (crc_arm),
    .crc_start (crc_start),
    .byte_vld  (byte_vld),
    .byte_val  (byte_val),
    .crc_ok    (crc_ok)
  );

  assign err_allow = regs.err_allow;
  assign blk_prot  = regs.blk_prot;
  assign frm_prot  = regs.frm_prot;
  assign ctl_a     = regs.ctl_a;
  assign ctl_b     = regs.ctl_b;

endmodule

// File: tb/sreg_crc_port_test.sv
`timescale 1ns/1ps
module sreg_crc_port_test;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
  logic [7:0] stat_in = 8'h00, blkno_in = 8'h00;
  logic sdo_pull_low, crc_ok;
  logic [7:0] err_allow, blk_prot, frm_prot, ctl_a, ctl_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sreg_crc_port #(.HOLDOFF_NS(4000)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en), .ser_din(ser_din),
    .stat_in(stat_in), .blkno_in(blkno_in), .sdo_pull_low(sdo_pull_low), .crc_ok(crc_ok),
    .err_allow(err_allow), .blk_prot(blk_prot), .frm_prot(frm_prot),
    .ctl_a(ctl_a), .ctl_b(ctl_b)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    wait_cyc(H);
    ser_clk = 1'b1;
    wait_cyc(H);
    ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic open_txn(input logic [7:0] addr);
    ser_en = 1'b0;
    send_byte(addr);
    wait_cyc(H);
    ser_en = 1'b1;
    wait_cyc(H);
  endtask

  task automatic close_txn();
    ser_en = 1'b0;
    wait_cyc(2 * H);
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [7:0] val);
    open_txn(8'hA1);
    for (int i = 0; i < 4; i++) send_bit(idx[i]);
    send_byte(val);
    close_txn();
  endtask

  function automatic logic [39:0] regs_now();
    return {err_allow, blk_prot, frm_prot, ctl_a, ctl_b};
  endfunction

  task automatic chk_regs(input string tag, input logic [39:0] exp);
    chk({tag, " err_allow"}, 16'(err_allow), 16'(exp[39:32]));
    chk({tag, " blk_prot"},  16'(blk_prot),  16'(exp[31:24]));
    chk({tag, " frm_prot"},  16'(frm_prot),  16'(exp[23:16]));
    chk({tag, " ctl_a"},     16'(ctl_a),     16'(exp[15:8]));
    chk({tag, " ctl_b"},     16'(ctl_b),     16'(exp[7:0]));
  endtask

  task automatic do_readback(input string tag, input logic [15:0] exp);
    logic [15:0] got;
    open_txn(8'hA2);
    for (int k = 0; k < 16; k++) begin
      got[k] = ~sdo_pull_low;
      send_bit(1'b0);
    end
    wait_cyc(H);
    chk({tag, " R5 readback word"}, got, exp);
    chk({tag, " R6 released after 16 bits"}, 16'(sdo_pull_low), 16'd0);
    close_txn();
    chk({tag, " R6 released with enable low"}, 16'(sdo_pull_low), 16'd0);
  endtask

  task automatic t_reset();
    chk("R9 registers zero", 16'(regs_now() != 40'd0), 16'd0);
    chk("R9 crc_ok high", 16'(crc_ok), 16'd1);
    chk("R9 data-out released", 16'(sdo_pull_low), 16'd0);
  endtask

  task automatic t_early_write();
    wr_reg(4'd1, 8'h3C);
    chk_regs("R4 write inside hold-off", 40'd0);
  endtask

  task automatic t_writes();
    wr_reg(4'd1, 8'h11);
    wr_reg(4'd2, 8'h82);
    wr_reg(4'd3, 8'h4D);
    wr_reg(4'd4, 8'hF0);
    wr_reg(4'd5, 8'h5A);
    chk_regs("R2 write all", {8'h11, 8'h82, 8'h4D, 8'hF0, 8'h5A});
  endtask

  task automatic t_reserved();
    wr_reg(4'd0, 8'hFF);
    wr_reg(4'd7, 8'hFF);
    wr_reg(4'd15, 8'hFF);
    wr_reg(4'd6, 8'hFF);
    chk_regs("R3 reserved indices", {8'h11, 8'h82, 8'h4D, 8'hF0, 8'h5A});
    open_txn(8'h55);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    send_byte(8'hEE);
    chk("R1 unknown address keeps line released", 16'(sdo_pull_low), 16'd0);
    close_txn();
    chk_regs("R1 unknown address", {8'h11, 8'h82, 8'h4D, 8'hF0, 8'h5A});
  endtask

  task automatic t_addr_last8();
    ser_en = 1'b0;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_byte(8'hA1);
    wait_cyc(H);
    ser_en = 1'b1;
    wait_cyc(H);
    for (int i = 0; i < 4; i++) send_bit(i == 1);
    send_byte(8'h27);
    send_bit(1'b1); send_bit(1'b1);
    close_txn();
    chk("R1 last eight address bits", 16'(blk_prot), 16'h0027);
    chk("R2 trailing bits ignored", 16'(err_allow), 16'h0011);
  endtask

  task automatic t_crc_split();
    string s = "123456789";
    wr_reg(4'd6, 8'h00);
    open_txn(8'hA3);
    for (int i = 0; i < 4; i++) send_byte(s[i]);
    close_txn();
    open_txn(8'hA3);
    for (int i = 4; i < 9; i++) send_byte(s[i]);
    close_txn();
    chk("R7 residue nonzero before check byte", 16'(crc_ok), 16'd0);
    do_readback("R5 status bit1 low", {8'h3C, 8'hA5 & 8'hFD});
    open_txn(8'hA3);
    send_byte(8'hF4);
    close_txn();
    chk("R8 split stream passes", 16'(crc_ok), 16'd1);
  endtask

  task automatic t_crc_restart();
    open_txn(8'hA3);
    send_byte(8'h01);
    close_txn();
    chk("R7 single byte fails", 16'(crc_ok), 16'd0);
    open_txn(8'hA3);
    close_txn();
    chk("R8 no clear without arm", 16'(crc_ok), 16'd0);
    wr_reg(4'd6, 8'h00);
    chk("R8 arm alone keeps residue", 16'(crc_ok), 16'd0);
    open_txn(8'hA3);
    close_txn();
    chk("R8 armed feed clears", 16'(crc_ok), 16'd1);
  endtask

  task automatic t_partial();
    open_txn(8'hA3);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    close_txn();
    chk("R7 partial byte dropped", 16'(crc_ok), 16'd1);
    open_txn(8'hA3);
    send_byte(8'h00);
    close_txn();
    chk("R7 byte alignment after partial", 16'(crc_ok), 16'd1);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    t_reset();
    t_early_write();
    wait_cyc(400);
    t_writes();
    t_reserved();
    t_addr_last8();
    stat_in  = 8'hA5;
    blkno_in = 8'h3C;
    do_readback("R5 status bit1 high", {8'h3C, 8'hA7});
    t_crc_split();
    stat_in  = 8'h5A;
    blkno_in = 8'hC3;
    do_readback("R5 second pattern", {8'hC3, 8'h5A});
    t_crc_restart();
    t_partial();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule